// File: doc/BRIEF.md
# Rotated Immediate Encoder

This block turns an unsigned immediate of up to 12 bits into the compact 12-bit immediate field used by a 32-bit data-processing instruction format. The field stores an 8-bit value and a 4-bit rotate count. The 32-bit operand that the field stands for is the 8-bit value rotated right, with wraparound, by twice the rotate count. The encoder looks for a value and rotate count that reproduce the input exactly. It reports whether such a pair exists. When more than one pair fits, it returns the one with the smallest rotate count.

A caller presents an immediate with a one-cycle request strobe. One clock edge later the block shows the result, with a result strobe, a flag that says whether the input can be encoded, and the 12-bit field. The block handles only magnitudes: the caller is responsible for any sign decision or negation.

Inside, every rotate count is tried at once. Each lane rotates the zero-extended input left by twice its count and tests whether only the low eight bits remain set. A priority selector then takes the lowest lane that matches. The result is stored in a register that is loaded only when a request arrives.

Top module: `rimm_encoder`

## Requirements
- R1: While rst_n is low, and after it is released until the first request, res_valid, res_ok and res_field are all 0.
- R2: res_valid is 1 in the cycle after a cycle in which req_valid is 1, and 0 in the cycle after a cycle in which req_valid is 0. The result of a request appears on res_ok and res_field in that same following cycle.
- R3: When res_ok is 1, decoding the field gives back the requested immediate. Decoding means: zero-extend res_field[7:0] to 32 bits and rotate it right by 2 × res_field[11:8] bit positions.
- R4: When several rotate counts can encode the input, res_field[11:8] holds the smallest of them.
- R5: Field layout: the rotate count is in res_field[11:8] and the 8-bit value is in res_field[7:0].
- R6: If no rotate count in 0..15 can encode the input, res_ok is 0 and res_field is 0.
- R7: An input of 0 gives res_ok = 1 and res_field = 0x000 (rotate 0, value 0).
- R8: In a cycle where req_valid is 0, res_ok and res_field keep their values at the next clock edge, whatever req_imm holds.
- R9: Fixed points of the encoding:
  - 0x800 encodes as 0xB02 (rotate 11, value 0x02).
  - 0x00C encodes as 0x00C (rotate 0, value 0x0C).
  - 0x770 encodes as 0xE77 (rotate 14, value 0x77; 0x77 rotated right by 28 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; loads the result register |
| req_imm | input | 12 | Unsigned immediate to encode |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_ok | output | 1 | 1 when the input has an encoding |
| res_field | output | 12 | Rotate count in [11:8], value in [7:0]; 0 when res_ok is 0 |

## Verification
The bench uses the default parameters: a 12-bit input, a 32-bit word, an 8-bit value and a 4-bit rotate count, which give 16 lanes. With these values all 4096 possible inputs can be swept one by one. Each result is compared with a brute-force search that rotates every (rotate, value) pair right and keeps the first exact match. The sweep therefore covers every input that has several encodings, where the smallest rotate must win. It also covers every input with no encoding, including the wide bit spans that can only fit by wrapping past bit 31.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
  localparam int unsigned IN_W_DEF   = 12;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned VAL_W_DEF  = 8;
  localparam int unsigned ROT_W_DEF  = 4;

  // bit positions moved per rotate step
  function automatic int unsigned rot_step(int unsigned word_w, int unsigned rot_w);
    return word_w / (1 << rot_w);
  endfunction
endpackage

// File: rtl/rimm_lane.sv
// One candidate rotate count: rotate the word left by SHIFT and test
// that only the low VAL_W bits survive.
module rimm_lane #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned SHIFT  = 0
) (
  input  logic [IN_W-1:0]  imm,
  output logic             hit,
  output logic [VAL_W-1:0] val
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rolled;

  always_comb begin
    word   = WORD_W'(imm);
    rolled = (word << SHIFT) | (word >> (WORD_W - SHIFT));
    hit    = ~|rolled[WORD_W-1:VAL_W];
    val    = rolled[VAL_W-1:0];
  end
endmodule

// File: rtl/rimm_prio.sv
// Lowest-index-first selector over the lane hits.
module rimm_prio #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R4: nothing below the chosen index may be requesting
  logic lower_clear;
  always_comb begin
    lower_clear = 1'b1;
    for (int j = 0; j < N; j++) begin
      if (j < int'(idx) && req[j]) lower_clear = 1'b0;
    end
    if (any) begin
      assert_lowest_R4: assert (lower_clear && req[idx]);
    end
  end
endmodule

// File: rtl/rimm_encoder.sv
module rimm_encoder #(
  parameter int unsigned IN_W   = rimm_pkg::IN_W_DEF,
  parameter int unsigned WORD_W = rimm_pkg::WORD_W_DEF,
  parameter int unsigned VAL_W  = rimm_pkg::VAL_W_DEF,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [IN_W-1:0]        req_imm,
  output logic                   res_valid,
  output logic                   res_ok,
  output logic [ROT_W+VAL_W-1:0] res_field
);
  localparam int unsigned NUM_ROT = 1 << ROT_W;
  localparam int unsigned STEP    = rimm_pkg::rot_step(WORD_W, ROT_W);
  localparam int unsigned FIELD_W = ROT_W + VAL_W;

  logic [NUM_ROT-1:0] lane_hit;
  logic [VAL_W-1:0]   lane_val [NUM_ROT];

  for (genvar r = 0; r < NUM_ROT; r++) begin : g_lane
    rimm_lane #(
      .IN_W  (IN_W),
      .WORD_W(WORD_W),
      .VAL_W (VAL_W),
      .SHIFT (r * STEP)
    ) u_lane (
      .imm(req_imm),
      .hit(lane_hit[r]),
      .val(lane_val[r])
    );
  end

  logic             hit_any;
  logic [ROT_W-1:0] sel_rot;
  logic [VAL_W-1:0] sel_val;

  rimm_prio #(
    .N    (NUM_ROT),
    .IDX_W(ROT_W)
  ) u_prio (
    .req(lane_hit),
    .any(hit_any),
    .idx(sel_rot)
  );

  assign sel_val = lane_val[sel_rot];

  // next-state
  logic               valid_d;
  logic               ok_d;
  logic [FIELD_W-1:0] field_d;

  always_comb begin
    valid_d = req_valid;
    ok_d    = res_ok;
    field_d = res_field;
    if (req_valid) begin
      ok_d    = hit_any;
      field_d = hit_any ? {sel_rot, sel_val} : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_field <= '0;
    end else begin
      res_valid <= valid_d;
      res_ok    <= ok_d;
      res_field <= field_d;
    end
  end

  // R3: decoding the selected pair with a right rotation gives the input back
  logic [WORD_W-1:0] decoded;
  int unsigned       ror_amt;
  always_comb begin
    ror_amt = int'(sel_rot) * STEP;
    decoded = (WORD_W'(sel_val) >> ror_amt) | (WORD_W'(sel_val) << (WORD_W - ror_amt));
    if (rst_n && hit_any) begin
      assert_decode_R3: assert (decoded == WORD_W'(req_imm));
    end
  end

  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_ok) && $stable(res_field)));
  assert_nofit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ok |-> (res_field == '0));
  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_imm == '0) |=> (res_ok && res_field == '0));
endmodule

// File: tb/rimm_encoder_tb.sv
module rimm_encoder_tb;
  localparam int IN_W   = 12;
  localparam int WORD_W = 32;
  localparam int VAL_W  = 8;
  localparam int ROT_W  = 4;
  localparam int FW     = ROT_W + VAL_W;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [IN_W-1:0] req_imm;
  logic          res_valid;
  logic          res_ok;
  logic [FW-1:0] res_field;

  int checks = 0;
  int errors = 0;

  rimm_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
    .res_valid(res_valid), .res_ok(res_ok), .res_field(res_field)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ror32(input logic [31:0] v, input int amt);
    if (amt == 0) return v;
    return (v >> amt) | (v << (32 - amt));
  endfunction

  // brute-force reference: {ok, rot, val}
  function automatic logic [12:0] ref_enc(input int x);
    for (int r = 0; r < 16; r++)
      for (int v = 0; v < 256; v++)
        if (ror32(32'(v), 2 * r) == 32'(x)) return {1'b1, 4'(r), 8'(v)};
    return 13'd0;
  endfunction

  task automatic apply(input int x);
    @(negedge clk);
    req_valid = 1'b1;
    req_imm   = IN_W'(x);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_one(input int x, input string tag);
    logic [12:0] e;
    e = ref_enc(x);
    apply(x);
    check(res_valid == 1'b1, "R2 res_valid after request", res_valid, 1);
    check({res_ok, res_field} == e, tag, {res_ok, res_field}, e);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_imm = '0;
    repeat (3) @(negedge clk);
    check({res_valid, res_ok, res_field} == 0, "R1 reset state", {res_valid, res_ok, res_field}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({res_valid, res_ok, res_field} == 0, "R1 after release", {res_valid, res_ok, res_field}, 0);

    // R9 fixed points
    check_one(12'h800, "R9 0x800");
    check(res_field == 12'hB02, "R9 0x800 field", res_field, 12'hB02);
    check_one(12'h00C, "R9 0x00C");
    check(res_field == 12'h00C, "R9 0x00C field", res_field, 12'h00C);
    check_one(12'h770, "R9 0x770");
    check(res_field == 12'hE77, "R9 0x770 field", res_field, 12'hE77);
    check_one(0, "R7 zero input");
    check(res_ok == 1'b1 && res_field == 0, "R7 zero field", {res_ok, res_field}, 13'h1000);
    check_one(12'h101, "R6 unencodable 0x101");
    check_one(12'hFFF, "R6 unencodable 0xFFF");

    // R8 hold with changing data and no request; R2 idle strobe
    apply(12'h00C);
    req_imm = 12'hFFF;
    @(negedge clk);
    req_imm = 12'h800;
    @(negedge clk);
    check(res_valid == 1'b0, "R2 no strobe when idle", res_valid, 0);
    check({res_ok, res_field} == 13'h100C, "R8 hold", {res_ok, res_field}, 13'h100C);

    // exhaustive sweep
    for (int x = 0; x < (1 << IN_W); x++) begin
      logic [12:0] e;
      e = ref_enc(x);
      apply(x);
      check(res_valid == 1'b1, "R2 strobe in sweep", res_valid, 1);
      if (!e[12])
        check(res_ok == 1'b0 && res_field == 0, "R6 no encoding", {res_ok, res_field}, 0);
      else begin
        check(res_field[11:8] == e[11:8], "R4 smallest rotate", res_field[11:8], e[11:8]);
        check(res_ok && res_field[7:0] == e[7:0], "R5 value field", {res_ok, res_field[7:0]}, {1'b1, e[7:0]});
        check(ror32(32'(res_field[7:0]), 2 * int'(res_field[11:8])) == 32'(x),
              "R3 decode round trip", res_field, x);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule